// File: doc/BRIEF.md
# Lowest-Bit Manipulation ALU

This block is a one-stage integer unit for scalar bit tricks on 64-bit or 32-bit operands. It covers the operations that find the lowest set or lowest clear bit of a word and then isolate it, clear it, set it, fill below it or build a mask from it. It also covers AND-NOT, bit-field extract and zeroing of the high bits. The operation code arrives already decoded. In 32-bit mode only the low halves of the operands are used and the upper half of the result is zero.

Operands enter through a valid/ready stream and results leave through a second valid/ready stream, one result per accepted operand set, in order. The block holds a single result register. It accepts a new operand set whenever that register is empty or its result is being taken in the same cycle, so `in_ready` follows `out_ready` combinationally. While `out_valid` is high and `out_ready` is low, the result and both flags stay frozen, and `in_ready` is low.

Top module: `lowbit_alu`

## Requirements
- R1: An operand set taken on a clock edge where `in_valid && in_ready` appears on `out_valid` and `out_res`/`out_zf`/`out_cf` right after that edge. `out_valid` is low whenever no result is pending.
- R2: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid && !out_ready`, the outputs hold their values on the next edge.
- R3: Code 0 (AND-NOT) gives `~A & B`.
- R4: The lowest-set-bit codes act on A, where `x` is A: 2 gives `x & -x`, 3 gives `x ^ (x-1)`, 4 gives `x & (x-1)`, 5 gives `x | (x-1)`, 6 gives `~x | (x-1)`, 7 gives `~x & (x-1)`.
- R5: The lowest-clear-bit codes act on A: 8 gives `x & (x+1)`, 9 gives `x | ~(x+1)`, 10 gives `~x & (x+1)`, 11 gives `x ^ (x+1)`, 12 gives `x | (x+1)`, 13 gives `~x | (x+1)`.
- R6: With `in_wide`=0, only bits [31:0] of A and B are used, the arithmetic wraps at 32 bits, and `out_res[63:32]` is zero. With `in_wide`=1, all 64 bits are used.
- R7: Code 1 (field extract) takes the start from B[7:0] and the length from B[15:8], and gives `(A >> start)` masked to its low `length` bits. A start at or beyond the operand width gives 0. A length at or beyond the width keeps every remaining bit.
- R8: Code 14 (zero high bits) takes an index from B[7:0] and clears bits `index` and up of A. An index at or beyond the operand width (32 or 64) returns A unchanged and sets the carry flag.
- R9: `out_zf` is 1 exactly when `out_res` is zero, for every code.
- R10: For codes 2 to 7, `out_cf` is 1 exactly when A (at the selected width) is zero. For codes 0, 1 and 8 to 13, `out_cf` is 0, and for code 14 it follows R8.
- R11: Codes 15 to 31 give result 0, `out_zf`=1 and `out_cf`=0.
- R12: While `rst_n` is low and right after it rises, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Operand set can be taken this cycle |
| in_op | input | 5 | Decoded operation code |
| in_wide | input | 1 | 1 selects 64-bit operands, 0 selects 32-bit |
| in_a | input | 64 | Source operand |
| in_b | input | 64 | Second operand or extract/index control |
| out_valid | output | 1 | Result pending |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_res | output | 64 | Result |
| out_zf | output | 1 | Result is zero |
| out_cf | output | 1 | Source zero or index overflow, per R10 and R8 |

## Verification
The bound checker looks at the handshake and flag rules on every cycle. It checks that an accepted set is presented after one edge and that a stalled result stays frozen with `in_ready` low. It also checks that the zero flag always matches the result, that a 32-bit operation leaves the upper half clear, that the carry stays low for the codes that never raise it, and that undefined codes produce a zero result. The arithmetic of each operation has to come from the bench's scenarios, because only a reference computation can supply the expected bits. The same holds for the field-extract and high-zero boundaries (start, length and index at and beyond 32 and 64) and for the carry on a zero source.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ANDNOT  = 5'd0,
    OP_FIELD   = 5'd1,
    OP_LS_ISO  = 5'd2,
    OP_LS_MSK  = 5'd3,
    OP_LS_CLR  = 5'd4,
    OP_LS_FILL = 5'd5,
    OP_LS_ISOC = 5'd6,
    OP_TZ_MSK  = 5'd7,
    OP_LC_FILL = 5'd8,
    OP_LC_ISO  = 5'd9,
    OP_LC_ISOC = 5'd10,
    OP_LC_MSK  = 5'd11,
    OP_LC_SET  = 5'd12,
    OP_TO_MSKC = 5'd13,
    OP_ZHI     = 5'd14
  } op_e;

endpackage

// File: rtl/lbm_lowbit_unit.sv
module lbm_lowbit_unit
  import lbm_pkg::*;
#(
  parameter int DW = 64
) (
  input  op_e           op,
  input  logic [DW-1:0] x,
  output logic [DW-1:0] res,
  output logic          ls_op
);

  logic [DW-1:0] dec;
  logic [DW-1:0] inc;

  // Two carry chains serve every code; the negation reuses the decrement.
  assign dec = x - {{(DW-1){1'b0}}, 1'b1};
  assign inc = x + {{(DW-1){1'b0}}, 1'b1};

  always_comb begin
    res   = '0;
    ls_op = 1'b0;
    unique case (op)
      OP_LS_ISO:  begin res = x & ~dec;  ls_op = 1'b1; end
      OP_LS_MSK:  begin res = x ^ dec;   ls_op = 1'b1; end
      OP_LS_CLR:  begin res = x & dec;   ls_op = 1'b1; end
      OP_LS_FILL: begin res = x | dec;   ls_op = 1'b1; end
      OP_LS_ISOC: begin res = ~x | dec;  ls_op = 1'b1; end
      OP_TZ_MSK:  begin res = ~x & dec;  ls_op = 1'b1; end
      OP_LC_FILL: res = x & inc;
      OP_LC_ISO:  res = x | ~inc;
      OP_LC_ISOC: res = ~x & inc;
      OP_LC_MSK:  res = x ^ inc;
      OP_LC_SET:  res = x | inc;
      OP_TO_MSKC: res = ~x | inc;
      default:    res = '0;
    endcase
  end

endmodule

// File: rtl/lbm_field_unit.sv
module lbm_field_unit #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] x,
  input  logic [15:0]   ctl,
  input  logic          wide,
  input  logic          zhi,
  output logic [DW-1:0] res,
  output logic          over
);

  localparam int HW = DW / 2;

  logic [7:0]    amt;
  logic [DW-1:0] src;
  logic [DW-1:0] therm;

  // Extract uses the length field as its mask size, high-zero uses the index.
  assign amt = zhi ? ctl[7:0] : ctl[15:8];
  assign src = zhi ? x : (x >> ctl[7:0]);

  // One shared thermometer mask: bit i kept when i < amt.
  for (genvar gi = 0; gi < DW; gi++) begin : g_therm
    assign therm[gi] = (int'(amt) > gi);
  end

  assign res  = src & therm;
  assign over = zhi && (int'(amt) >= (wide ? DW : HW));

endmodule

// File: rtl/lbm_out_stage.sv
module lbm_out_stage #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] d_res,
  input  logic          d_zf,
  input  logic          d_cf,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_res,
  output logic          out_zf,
  output logic          out_cf
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_res <= '0;
      out_zf  <= 1'b1;
      out_cf  <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_res <= d_res;
      out_zf  <= d_zf;
      out_cf  <= d_cf;
    end
  end

endmodule

// File: rtl/lowbit_alu.sv
module lowbit_alu
  import lbm_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [OPW-1:0] in_op,
  input  logic           in_wide,
  input  logic [DW-1:0]  in_a,
  input  logic [DW-1:0]  in_b,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_res,
  output logic           out_zf,
  output logic           out_cf
);

  localparam int HW = DW / 2;
  localparam logic [DW-1:0] NARROW_M = {{HW{1'b0}}, {HW{1'b1}}};

  op_e           op;
  logic [DW-1:0] lane_m;
  logic [DW-1:0] x;
  logic [DW-1:0] y;
  logic [DW-1:0] low_res;
  logic          ls_op;
  logic [DW-1:0] fld_res;
  logic          fld_over;
  logic [DW-1:0] sel_res;
  logic [DW-1:0] fin_res;
  logic          fin_zf;
  logic          fin_cf;

  assign op     = op_e'(in_op);
  assign lane_m = in_wide ? {DW{1'b1}} : NARROW_M;
  assign x      = in_a & lane_m;
  assign y      = in_b & lane_m;

  lbm_lowbit_unit #(.DW(DW)) u_low (
    .op    (op),
    .x     (x),
    .res   (low_res),
    .ls_op (ls_op)
  );

  lbm_field_unit #(.DW(DW)) u_fld (
    .x    (x),
    .ctl  (in_b[15:0]),
    .wide (in_wide),
    .zhi  (op == OP_ZHI),
    .res  (fld_res),
    .over (fld_over)
  );

  always_comb begin
    unique case (op)
      OP_ANDNOT:        sel_res = ~x & y;
      OP_FIELD, OP_ZHI: sel_res = fld_res;
      OP_LS_ISO, OP_LS_MSK, OP_LS_CLR, OP_LS_FILL, OP_LS_ISOC, OP_TZ_MSK,
      OP_LC_FILL, OP_LC_ISO, OP_LC_ISOC, OP_LC_MSK, OP_LC_SET, OP_TO_MSKC:
                        sel_res = low_res;
      default:          sel_res = '0;
    endcase
  end

  // Full-width arithmetic wraps correctly at 32 bits once the upper lane is cut.
  assign fin_res = sel_res & lane_m;
  assign fin_zf  = (fin_res == '0);
  assign fin_cf  = ls_op ? (x == '0) : ((op == OP_ZHI) && fld_over);

  lbm_out_stage #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_res     (fin_res),
    .d_zf      (fin_zf),
    .d_cf      (fin_cf),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_res   (out_res),
    .out_zf    (out_zf),
    .out_cf    (out_cf)
  );

endmodule

// File: rtl/lowbit_alu_chk.sv
module lowbit_alu_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [4:0]    in_op,
  input logic          in_wide,
  input logic [DW-1:0] in_a,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_res,
  input logic          out_zf,
  input logic          out_cf
);

  localparam int HW = DW / 2;

  logic take;
  logic src_zero;
  assign take     = in_valid && in_ready;
  assign src_zero = in_wide ? (in_a == '0) : (in_a[HW-1:0] == '0);

  // R1
  accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_zf) && $stable(out_cf)));

  // R2
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R6
  narrow_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_wide) |=> (out_res[DW-1:HW] == '0));

  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_zf == (out_res == '0)));

  // R10
  carry_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_op <= 5'd1 || (in_op >= 5'd8 && in_op <= 5'd13) || in_op >= 5'd15)) |=> !out_cf);

  // R10
  carry_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op >= 5'd2 && in_op <= 5'd7) |=> (out_cf == $past(src_zero)));

  // R11
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op >= 5'd15) |=> (out_res == '0 && out_zf));

endmodule

bind lowbit_alu lowbit_alu_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .in_wide   (in_wide),
  .in_a      (in_a),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_res   (out_res),
  .out_zf    (out_zf),
  .out_cf    (out_cf)
);

// File: tb/lowbit_alu_bench.sv
module lowbit_alu_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_op = '0;
  logic        in_wide = 1'b1;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_res;
  logic        out_zf;
  logic        out_cf;

  int nchk = 0;
  int nfail = 0;
  int ready_mode = 0;
  bit done = 0;

  logic [63:0] qr[$];
  bit          qz[$];
  bit          qc[$];
  string       qt[$];

  always #10 clk = ~clk;

  lowbit_alu u_lowbit_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_wide(in_wide), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
    .out_zf(out_zf), .out_cf(out_cf)
  );

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void model(input int op, input bit wide, input logic [63:0] a,
                                input logic [63:0] b, output logic [63:0] r,
                                output bit z, output bit c);
    logic [63:0] m, x, y;
    int w, st, ln;
    w = wide ? 64 : 32;
    m = wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    x = a & m;
    y = b & m;
    c = 0;
    case (op)
      0: r = ~x & y;
      1: begin
        st = int'(b[7:0]);
        ln = int'(b[15:8]);
        r = (st >= w) ? 64'd0 : (x >> st);
        if (ln < w) r = r & ((64'd1 << ln) - 64'd1);
      end
      2: r = x & (-x);
      3: r = x ^ (x - 64'd1);
      4: r = x & (x - 64'd1);
      5: r = x | (x - 64'd1);
      6: r = ~x | (x - 64'd1);
      7: r = ~x & (x - 64'd1);
      8: r = x & (x + 64'd1);
      9: r = x | ~(x + 64'd1);
      10: r = ~x & (x + 64'd1);
      11: r = x ^ (x + 64'd1);
      12: r = x | (x + 64'd1);
      13: r = ~x | (x + 64'd1);
      14: begin
        st = int'(b[7:0]);
        if (st >= w) begin r = x; c = 1; end
        else r = x & ((64'd1 << st) - 64'd1);
      end
      default: r = 64'd0;
    endcase
    if (op >= 2 && op <= 7) c = (x == 64'd0);
    r = r & m;
    z = (r == 64'd0);
  endfunction

  function automatic string tag_of(int op, bit wide);
    string s;
    if (op == 0) s = "R3";
    else if (op == 1) s = "R7";
    else if (op <= 7) s = "R4 R10";
    else if (op <= 13) s = "R5 R10";
    else if (op == 14) s = "R8 R10";
    else s = "R11";
    if (!wide) s = {s, " R6"};
    return {s, " R9"};
  endfunction

  function automatic bit pick_ready();
    case (ready_mode)
      0: return 1'b1;
      1: return ($urandom_range(0, 9) < 7);
      default: return ($urandom_range(0, 9) < 2);
    endcase
  endfunction

  // Called 1 ns after inputs are driven at a falling edge.
  task automatic observe(output bit took);
    bit ev;
    logic [63:0] r;
    bit z, c;
    #1;
    ev = (qr.size() != 0);
    chk(out_valid == ev, "R1", "out_valid", 64'(out_valid), 64'(ev));
    chk(in_ready == (!ev || out_ready), "R2", "in_ready", 64'(in_ready), 64'(!ev || out_ready));
    if (out_valid && ev) begin
      chk(out_res == qr[0], qt[0], "result", out_res, qr[0]);
      chk(out_zf == qz[0], qt[0], "zero flag", 64'(out_zf), 64'(qz[0]));
      chk(out_cf == qc[0], qt[0], "carry flag", 64'(out_cf), 64'(qc[0]));
    end
    if (out_valid && out_ready && ev) begin
      void'(qr.pop_front()); void'(qz.pop_front());
      void'(qc.pop_front()); void'(qt.pop_front());
    end
    took = in_valid && in_ready;
    if (took) begin
      model(int'(in_op), in_wide, in_a, in_b, r, z, c);
      qr.push_back(r); qz.push_back(z); qc.push_back(c);
      qt.push_back(tag_of(int'(in_op), in_wide));
    end
  endtask

  task automatic send(int op, bit wide, logic [63:0] a, logic [63:0] b);
    bit took;
    took = 0;
    while (!took) begin
      @(negedge clk);
      out_ready = pick_ready();
      in_valid = 1'b1;
      in_op = 5'(op);
      in_wide = wide;
      in_a = a;
      in_b = b;
      observe(took);
    end
  endtask

  task automatic idle();
    bit took;
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = pick_ready();
    observe(took);
  endtask

  function automatic logic [63:0] pick_operand();
    case ($urandom_range(0, 5))
      0: return 64'd0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return {$urandom(), $urandom()} << $urandom_range(0, 63);
      3: return ~({$urandom(), $urandom()} << $urandom_range(0, 63));
      4: return 64'(1) << $urandom_range(0, 63);
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", nchk, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: state under reset
    chk(out_valid == 1'b0, "R12", "out_valid in reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R12", "in_ready in reset", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R12", "out_valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R12", "in_ready after reset", 64'(in_ready), 64'd1);

    ready_mode = 0;
    // R3: AND-NOT
    send(0, 1, 64'hF0F0_0000_FFFF_1234, 64'hFFFF_FFFF_0F0F_FFFF);
    send(0, 0, 64'hF0F0_0000_FFFF_1234, 64'hFFFF_FFFF_0F0F_FFFF);
    // R4, R10: lowest-set codes on zero (carry set) and on typical words
    for (int op = 2; op <= 7; op++) begin
      send(op, 1, 64'd0, 64'd0);
      send(op, 0, 64'hABCD_0000_0000_0000, 64'd0);
      send(op, 1, 64'h0000_0000_000F_0000, 64'd0);
      send(op, 0, 64'h8000_0000_8000_0000, 64'd0);
    end
    // R5: lowest-clear codes on all ones, wrapping at each width
    for (int op = 8; op <= 13; op++) begin
      send(op, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
      send(op, 0, 64'h0000_0000_FFFF_FFFF, 64'd0);
      send(op, 1, 64'h0000_0000_0000_00FF, 64'd0);
      send(op, 0, 64'h1234_5678_7FFF_FFFF, 64'd0);
    end
    // R7: extract, normal field and start/length boundaries
    send(1, 0, 64'h0000_0000_1234_5678, 64'h0000_0000_0000_0804);
    send(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0840);
    send(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0820);
    send(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_081F);
    send(1, 1, 64'h8765_4321_0FED_CBA9, 64'h0000_0000_0000_C804);
    send(1, 0, 64'h8765_4321_0FED_CBA9, 64'h0000_0000_0000_2004);
    send(1, 1, 64'h8765_4321_0FED_CBA9, 64'h0000_0000_0000_0010);
    // R8: high-zero index boundaries
    send(14, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
    send(14, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd31);
    send(14, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd32);
    send(14, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd63);
    send(14, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd64);
    send(14, 1, 64'h0123_4567_89AB_CDEF, 64'hFF00_0000_0000_00FF);
    // R11: undefined codes
    send(15, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF);
    send(31, 0, 64'h1234, 64'h1234);

    // R2: back-pressure and random mix under varied consumer behaviour
    for (int i = 0; i < 6000; i++) begin
      int op;
      logic [63:0] b;
      if (i % 1500 == 0) ready_mode = (i / 1500) % 3;
      op = int'($urandom_range(0, 16));
      if (op == 16) op = int'($urandom_range(15, 31));
      b = pick_operand();
      if (op == 1 || op == 14) begin
        b[7:0]  = 8'($urandom_range(0, 3) == 0 ? $urandom_range(0, 255) : $urandom_range(0, 70));
        b[15:8] = 8'($urandom_range(0, 3) == 0 ? $urandom_range(0, 255) : $urandom_range(0, 70));
      end
      if ($urandom_range(0, 7) == 0) idle();
      send(op, 1'($urandom_range(0, 1)), pick_operand(), b);
    end

    ready_mode = 0;
    repeat (4) idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule